// File: doc/BRIEF.md
# Card Presence Debounce and Fault Monitor

This block watches the mechanical card-presence switch of a smart card reader and tells the host, through one active-low status output, whether a card is usable. A card counts as inserted only after the switch has stayed closed for a long, unbroken run of slow-oscillator ticks. A card counts as removed on the first clock edge after the switch opens.

While the host holds the session command low, the block also supervises the session. Any of four faults ends it: a filtered overcurrent, a supply droop, overtemperature, or the loss of the card. On the first fault the block emits a one-cycle emergency-deactivation request and latches the fault, which holds the status output low. When the host raises the command again, the latch clears and the status output shows card presence again. This lets the host tell a hardware fault from a removed card.

Outside a session, overcurrent and overtemperature are ignored. A rising supply droop only produces a one-cycle internal power-on-reset pulse.

Top module: `card_presence_monitor`

## Requirements
- R1: With the presence input held high, `status_o` goes high on the clock edge that follows the edge at which the DEB_TICKS-th `tick_i` pulse is sampled. It stays low until then.
- R2: If the presence input goes low at any point during the insertion window, the tick count restarts from zero. A full DEB_TICKS further ticks are then needed.
- R3: On the first clock edge at which the presence input is sampled low, `status_o` goes low. If a session is active (`sess_n_i` low), one `emerg_o` pulse is issued on that same edge.
- R4: With `sess_n_i` high, the overcurrent and overtemperature inputs have no effect: `status_o` is unchanged and `emerg_o` stays low.
- R5: With `sess_n_i` high, a rising edge on `droop_i` gives exactly one `por_o` pulse, one clock long, and does not change `status_o`.
- R6: With `sess_n_i` low, `droop_i` or `ovt_i` high drives `status_o` low and gives one `emerg_o` pulse on the next clock edge.
- R7: An overcurrent becomes a fault only after `ovc_i` has stayed high for OC_TICKS consecutive `tick_i` pulses. A low cycle on `ovc_i` restarts that count.
- R8: After a session fault, `status_o` stays low and no further `emerg_o` pulse occurs until `sess_n_i` goes high. One clock edge after that, `status_o` again equals debounced card presence.
- R9: After synchronous reset, `status_o`, `emerg_o` and `por_o` are all low.
- R10: With `sess_n_i` low, `droop_i` does not produce a `por_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per slow-oscillator period |
| pres_i | input | 1 | Presence switch level, high = card inserted (synchronous) |
| sess_n_i | input | 1 | Session command, low = session active |
| ovc_i | input | 1 | Raw overcurrent flag |
| droop_i | input | 1 | Main supply droop flag |
| ovt_i | input | 1 | Overtemperature flag |
| status_o | output | 1 | Active-low status: high = card present and no fault |
| emerg_o | output | 1 | One-cycle emergency-deactivation request |
| por_o | output | 1 | One-cycle internal power-on-reset pulse |

## Verification
On every cycle, the assertions check the following:
- the emergency request lasts a single cycle and coincides with a low status output;
- a latched fault keeps status low;
- a confirmed card always follows a high presence level, and a low presence level clears it at the next edge;
- the overcurrent fault rises only after a high flag;
- the reset pulse never appears inside a session.

Only the bench scenarios show the exact counts:
- that insertion needs exactly DEB_TICKS ticks, and that an interruption at any tick position restarts the count;
- that the overcurrent filter needs exactly OC_TICKS ticks;
- that status recovers after the host ends a faulted session.

// File: rtl/card_mon_pkg.sv
package card_mon_pkg;

  typedef struct packed {
    logic removed;
    logic overcur;
    logic droop;
    logic overtemp;
  } fault_src_t;

endpackage

// File: rtl/cm_presence_debounce.sv
module cm_presence_debounce #(
  parameter int DEB_TICKS = 640
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic pres_i,
  output logic card_ok_o
);
  localparam int CW = $clog2(DEB_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          ok_q;

  always_ff @(posedge clk) begin
    if (rst || !pres_i) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!ok_q && tick_i) begin
      if (cnt_q == CW'(DEB_TICKS - 1)) begin
        ok_q  <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign card_ok_o = ok_q;

  // R3: a low presence level clears the confirmed card at the next edge
  p_drop_clears_r3: assert property (@(posedge clk) disable iff (rst)
    !pres_i |=> !ok_q);
  // R1: confirmation only follows a high presence level
  p_confirm_high_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_q) |-> $past(pres_i));
endmodule

// File: rtl/cm_overcurrent_filter.sv
module cm_overcurrent_filter #(
  parameter int OC_TICKS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic ovc_i,
  output logic flt_o
);
  localparam int CW = $clog2(OC_TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !ovc_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != CW'(OC_TICKS)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flt_o = (cnt_q == CW'(OC_TICKS));

  // R7: the filtered fault rises only after a high raw flag
  p_flt_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(flt_o) |-> $past(ovc_i));
endmodule

// File: rtl/cm_fault_supervisor.sv
module cm_fault_supervisor
  import card_mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sess_n_i,
  input  logic card_ok_i,
  input  logic pres_i,
  input  logic ovc_flt_i,
  input  logic droop_i,
  input  logic ovt_i,
  output logic status_o,
  output logic emerg_o,
  output logic por_o
);
  fault_src_t src;
  logic       in_sess;
  logic       present;
  logic       fault_now;
  logic       fault_q;
  logic       droop_q;
  logic       status_q;
  logic       emerg_q;
  logic       por_q;

  assign in_sess      = !sess_n_i;
  assign present      = card_ok_i && pres_i;
  assign src.removed  = !present;
  assign src.overcur  = ovc_flt_i;
  assign src.droop    = droop_i;
  assign src.overtemp = ovt_i;
  assign fault_now    = in_sess && (|src);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q  <= 1'b0;
      droop_q  <= 1'b0;
      status_q <= 1'b0;
      emerg_q  <= 1'b0;
      por_q    <= 1'b0;
    end else begin
      droop_q  <= droop_i;
      por_q    <= sess_n_i && droop_i && !droop_q;
      emerg_q  <= fault_now && !fault_q;
      if (sess_n_i)       fault_q <= 1'b0;
      else if (fault_now) fault_q <= 1'b1;
      status_q <= present && !fault_now && !(fault_q && in_sess);
    end
  end

  assign status_o = status_q;
  assign emerg_o  = emerg_q;
  assign por_o    = por_q;

  // R8: while a fault is latched the status output stays low
  p_latched_low_r8: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> !status_q);
  // R10: no reset pulse inside a session
  p_por_outside_r10: assert property (@(posedge clk) disable iff (rst)
    por_q |-> $past(sess_n_i));
endmodule

// File: rtl/card_presence_monitor.sv
module card_presence_monitor #(
  parameter int DEB_TICKS = 640,
  parameter int OC_TICKS  = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic pres_i,
  input  logic sess_n_i,
  input  logic ovc_i,
  input  logic droop_i,
  input  logic ovt_i,
  output logic status_o,
  output logic emerg_o,
  output logic por_o
);
  logic card_ok;
  logic ovc_flt;

  cm_presence_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst(rst), .tick_i(tick_i), .pres_i(pres_i),
    .card_ok_o(card_ok)
  );

  cm_overcurrent_filter #(.OC_TICKS(OC_TICKS)) u_ocf (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ovc_i(ovc_i),
    .flt_o(ovc_flt)
  );

  cm_fault_supervisor u_sup (
    .clk(clk), .rst(rst), .sess_n_i(sess_n_i), .card_ok_i(card_ok),
    .pres_i(pres_i), .ovc_flt_i(ovc_flt), .droop_i(droop_i),
    .ovt_i(ovt_i), .status_o(status_o), .emerg_o(emerg_o), .por_o(por_o)
  );

  // R8: the emergency request is a single-cycle pulse
  p_emerg_single_r8: assert property (@(posedge clk) disable iff (rst)
    emerg_o |=> !emerg_o);
  // R6: an emergency request comes with a low status
  p_emerg_status_r6: assert property (@(posedge clk) disable iff (rst)
    emerg_o |-> !status_o);
  // R9: outputs low right after reset
  p_reset_quiet_r9: assert property (@(posedge clk)
    $past(rst) |-> (!status_o && !emerg_o && !por_o));
endmodule

// File: tb/card_presence_monitor_bench.sv
`timescale 1ns/1ps
module card_presence_monitor_bench;
  localparam int DEB = 6;
  localparam int OC  = 4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, pres = 1'b0, sess_n = 1'b1;
  logic ovc = 1'b0, droop = 1'b0, ovt = 1'b0;
  logic status, emerg, por;
  int   checks = 0, errors = 0, emerg_cnt = 0, por_cnt = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  card_presence_monitor #(.DEB_TICKS(DEB), .OC_TICKS(OC)) u_card_presence_monitor (
    .clk(clk), .rst(rst), .tick_i(tick), .pres_i(pres), .sess_n_i(sess_n),
    .ovc_i(ovc), .droop_i(droop), .ovt_i(ovt),
    .status_o(status), .emerg_o(emerg), .por_o(por)
  );

  always @(negedge clk) begin
    if (emerg) emerg_cnt++;
    if (por)   por_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int e0, p0;
    idle(3);
    check("R9 status after reset", status, 0);
    check("R9 emerg after reset", emerg, 0);
    check("R9 por after reset", por, 0);
    @(negedge clk) rst = 1'b0;

    // R1 and R2: interrupt at every tick position, then debounce fully
    for (int k = 1; k < DEB; k++) begin
      pres = 1'b1;
      ticks(k);
      pres = 1'b0;
      idle(1);
      pres = 1'b1;
      ticks(DEB - 1);
      check("R2 restart after drop", status, 0);
      ticks(1);
      check("R1 insertion confirmed", status, 1);
      @(negedge clk) pres = 1'b0;
      @(negedge clk);
      check("R3 removal outside session", status, 0);
    end

    // Insert a card for the rest
    pres = 1'b1;
    ticks(DEB);
    check("R1 card inserted", status, 1);

    // R4: overcurrent and overtemperature ignored outside a session
    e0 = emerg_cnt;
    ovc = 1'b1; ovt = 1'b1;
    ticks(OC + 2);
    check("R4 status outside session", status, 1);
    check("R4 no emerg outside session", emerg_cnt - e0, 0);
    ovc = 1'b0; ovt = 1'b0;
    idle(2);

    // R5: droop outside a session
    p0 = por_cnt;
    droop = 1'b1; idle(3); droop = 1'b0; idle(2);
    check("R5 one por pulse", por_cnt - p0, 1);
    check("R5 status unchanged", status, 1);

    // R6, R8, R10: droop inside a session
    sess_n = 1'b0; idle(2);
    check("R6 status in healthy session", status, 1);
    e0 = emerg_cnt; p0 = por_cnt;
    droop = 1'b1; idle(2);
    check("R6 status on droop", status, 0);
    droop = 1'b0; idle(2);
    check("R6 one emerg on droop", emerg_cnt - e0, 1);
    check("R10 no por in session", por_cnt - p0, 0);
    check("R8 status stays low", status, 0);
    ovt = 1'b1; idle(3); ovt = 1'b0;
    check("R8 no second emerg", emerg_cnt - e0, 1);
    sess_n = 1'b1; idle(2);
    check("R8 recheck shows card", status, 1);

    // R6: overtemperature in session
    sess_n = 1'b0; idle(2);
    e0 = emerg_cnt;
    ovt = 1'b1; idle(2); ovt = 1'b0;
    check("R6 status on overtemp", status, 0);
    check("R6 one emerg on overtemp", emerg_cnt - e0, 1);
    sess_n = 1'b1; idle(2);

    // R7: overcurrent filter
    sess_n = 1'b0; idle(2);
    e0 = emerg_cnt;
    ovc = 1'b1;
    ticks(OC - 1);
    ovc = 1'b0; idle(1); ovc = 1'b1;
    ticks(OC - 1);
    check("R7 short overcurrent ignored", status, 1);
    check("R7 no emerg yet", emerg_cnt - e0, 0);
    ticks(1);
    check("R7 overcurrent declared", status, 0);
    check("R7 one emerg", emerg_cnt - e0, 1);
    ovc = 1'b0;
    sess_n = 1'b1; idle(2);
    check("R8 recovery after overcurrent", status, 1);

    // R3: removal inside a session
    sess_n = 1'b0; idle(2);
    e0 = emerg_cnt;
    @(negedge clk) pres = 1'b0;
    @(negedge clk);
    check("R3 status on removal in session", status, 0);
    idle(1);
    check("R3 emerg on removal", emerg_cnt - e0, 1);
    sess_n = 1'b1; idle(2);
    check("R8 recheck shows no card", status, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule